// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interpreter of a byte-wide parallel NOR flash. It watches qualified write cycles, each carrying a 19-bit address and an 8-bit data byte, and recognises the two-write unlock prefix that guards every multi-cycle command. From this it steers a mode register among read, identifier read, program arming, programming, erase setup, sector collection window, erasing, erase-suspended and fail. The array engine behind it is abstract. The engine receives one-cycle start, suspend and resume pulses and a bitmap of the sectors to erase. It reports back through busy, done and fail flags.

Sector erase uses a restartable collection window. Each additional sector-erase write adds a sector and restarts the window, and the erase starts only when the window runs out. The window length is `CLK_FREQ_MHZ * WINDOW_US` clock cycles. Some reset and suspend writes are honoured in one mode and ignored in another. This mode-dependent acceptance is the core of the block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Reset state: mode 0 (read), the sector bitmap is 0 and every pulse output is low. The five pulse outputs are each one cycle long, and no two are high in the same cycle.
- R2: The unlock prefix is 0xAA written at an address whose low 11 bits are 0x555, followed by 0x55 at low bits 0x2AA. Writing 0x90 at 0x555 after the prefix enters mode 1 (identifier). A write of 0xF0 at any address leaves mode 1 and returns to the mode held before it, either 0 or 7.
- R3: Writing 0xA0 at 0x555 after the prefix enters mode 2 (program armed). The next write pulses prog_start and enters mode 3. When the engine reports done, the block returns to the mode it was in before arming.
- R4: In mode 3, and during a chip erase, every write is ignored, including 0xF0 and 0xB0.
- R5: Writing 0x80 at 0x555 after the prefix enters mode 4. A second prefix followed by 0x10 at 0x555 pulses chip_erase_start, enters mode 6 and sets all bitmap bits.
- R6: In mode 4, a second prefix followed by 0x30 at any address enters mode 5 (window). That write sets the bitmap bit selected by address bits 18..16. Each further 0x30 write in mode 5 adds its sector to the bitmap.
- R7: The window ends WIN_CYCLES cycles after the latest 0x30 write, and each new 0x30 write restarts it. The block then pulses sector_erase_start and enters mode 6.
- R8: In mode 5, any write other than 0x30 or 0xB0 aborts the erase. The block returns to mode 0 and clears the bitmap.
- R9: 0xB0 in mode 5 enters mode 7 (suspended) at once, with no pulse. 0xB0 during a sector erase in mode 6 pulses suspend_req and enters mode 7.
- R10: 0x30 in mode 7 enters mode 6. It pulses resume_req if the erase had already started, or sector_erase_start if it was suspended inside the window. 0x30 written in mode 0 has no effect.
- R11: In mode 7, the program and identifier commands are accepted and finish back in mode 7. The erase-setup command 0x80 is rejected and the block stays in mode 7.
- R12: A write that breaks the unlock prefix, or a command byte written at the wrong address, discards the partial sequence. An erase setup broken this way returns to mode 0.
- R13: An engine fail report during programming or erasing enters mode 8. Only a 0xF0 write leaves it, back to mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Qualified write cycle strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| eng_busy | input | 1 | Array engine busy (observed only) |
| eng_done | input | 1 | Engine finished the running operation |
| eng_fail | input | 1 | Engine operation failed |
| mode_o | output | 4 | Current mode code |
| prog_start | output | 1 | Start pulse for a byte program |
| chip_erase_start | output | 1 | Start pulse for chip erase |
| sector_erase_start | output | 1 | Start pulse for sector erase |
| sector_map | output | 8 | Bitmap of sectors queued for erase |
| suspend_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |

## Verification
The bound checker watches every cycle for properties that hold regardless of stimulus:
- pulse exclusivity and one-cycle width;
- the hold of program mode and chip-erase mode against incoming writes;
- the stickiness of the fail mode;
- resume only from the suspended mode;
- a non-empty bitmap whenever an erase starts.

Some behaviours need scripted scenarios in the bench instead. These are the exact window length and its restart, the per-sector bitmap decode across all eight sectors, and abort, suspend and resume ordering. The bench also covers the return to the correct stable mode after identifier reads and programs issued while suspended.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    MD_READ    = 4'd0,
    MD_IDENT   = 4'd1,
    MD_PGM_ARM = 4'd2,
    MD_PGM     = 4'd3,
    MD_ESETUP  = 4'd4,
    MD_WINDOW  = 4'd5,
    MD_ERASE   = 4'd6,
    MD_SUSP    = 4'd7,
    MD_FAIL    = 4'd8
  } mode_e;

  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] K_KEY1   = 8'hAA;
  localparam logic [CMD_W-1:0] K_KEY2   = 8'h55;
  localparam logic [CMD_W-1:0] K_IDENT  = 8'h90;
  localparam logic [CMD_W-1:0] K_PGM    = 8'hA0;
  localparam logic [CMD_W-1:0] K_ERASE  = 8'h80;
  localparam logic [CMD_W-1:0] K_CHIP   = 8'h10;
  localparam logic [CMD_W-1:0] K_SECTOR = 8'h30;
  localparam logic [CMD_W-1:0] K_SUSP   = 8'hB0;
  localparam logic [CMD_W-1:0] K_RESET  = 8'hF0;
endpackage

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             clear,
  input  logic [CMP_W-1:0] addr_lo,
  input  logic [CMD_W-1:0] data,
  output logic             cmd_o,
  output logic             brk_o
);
  localparam logic [CMP_W-1:0] ADR_FIRST  = CMP_W'('h555);
  localparam logic [CMP_W-1:0] ADR_SECOND = CMP_W'('h2AA);

  logic [1:0] stage_q;
  logic       m_first, m_second;

  assign m_first  = (addr_lo == ADR_FIRST)  && (data == K_KEY1);
  assign m_second = (addr_lo == ADR_SECOND) && (data == K_KEY2);
  assign cmd_o    = wr_en && (stage_q == 2'd2);
  assign brk_o    = wr_en && (((stage_q == 2'd0) && !m_first) ||
                              ((stage_q == 2'd1) && !m_second));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      stage_q <= 2'd0;
    end else if (wr_en) begin
      case (stage_q)
        2'd0:    stage_q <= m_first  ? 2'd1 : 2'd0;
        2'd1:    stage_q <= m_second ? 2'd2 : 2'd0;
        default: stage_q <= 2'd0;
      endcase
    end
  end
endmodule

// File: rtl/flash_window_timer.sv
module flash_window_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] START = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= START;
    end else if (load) begin
      cnt_q <= START;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int SECT_BITS    = 3,
  parameter int UNLOCK_W     = 11,
  parameter int CLK_FREQ_MHZ = 100,
  parameter int WINDOW_US    = 50
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic                    eng_busy,
  input  logic                    eng_done,
  input  logic                    eng_fail,
  output logic [3:0]              mode_o,
  output logic                    prog_start,
  output logic                    chip_erase_start,
  output logic                    sector_erase_start,
  output logic [(1<<SECT_BITS)-1:0] sector_map,
  output logic                    suspend_req,
  output logic                    resume_req
);
  localparam int NUM_SECT   = 1 << SECT_BITS;
  localparam int WIN_CYCLES = CLK_FREQ_MHZ * WINDOW_US;
  localparam logic [UNLOCK_W-1:0] ADR_CMD = UNLOCK_W'('h555);

  mode_e                mode_q;
  logic [NUM_SECT-1:0]  map_q, sect_bit;
  logic [SECT_BITS-1:0] sect_idx;
  logic                 susp_q, started_q, chip_q;
  logic                 is_reset, listen, trk_cmd, trk_brk, at_cmd;
  logic                 win_load, win_expire;
  logic                 unused_inputs;

  assign is_reset = wr_en && (wr_data == K_RESET);
  assign listen   = (mode_q == MD_READ) || (mode_q == MD_SUSP) || (mode_q == MD_ESETUP);
  assign at_cmd   = (wr_addr[UNLOCK_W-1:0] == ADR_CMD);
  assign sect_idx = wr_addr[ADDR_W-1 -: SECT_BITS];
  assign unused_inputs = eng_busy ^ (^wr_addr[ADDR_W-SECT_BITS-1:UNLOCK_W]);

  generate
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect_dec
      assign sect_bit[g] = (sect_idx == SECT_BITS'(g));
    end
  endgenerate

  flash_unlock_seq #(.CMP_W(UNLOCK_W)) unlock_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en && listen && !is_reset),
    .clear   (is_reset),
    .addr_lo (wr_addr[UNLOCK_W-1:0]),
    .data    (wr_data),
    .cmd_o   (trk_cmd),
    .brk_o   (trk_brk)
  );

  assign win_load = ((mode_q == MD_ESETUP) && trk_cmd && (wr_data == K_SECTOR)) ||
                    ((mode_q == MD_WINDOW) && wr_en && (wr_data == K_SECTOR));

  flash_window_timer #(.CYCLES(WIN_CYCLES)) window_i (
    .clk    (clk),
    .rst    (rst),
    .load   (win_load),
    .run    (mode_q == MD_WINDOW),
    .expire (win_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_READ;  map_q <= '0;
      susp_q <= 1'b0;  started_q <= 1'b0;  chip_q <= 1'b0;
      prog_start <= 1'b0;  chip_erase_start <= 1'b0;  sector_erase_start <= 1'b0;
      suspend_req <= 1'b0;  resume_req <= 1'b0;
    end else begin
      prog_start <= 1'b0;  chip_erase_start <= 1'b0;  sector_erase_start <= 1'b0;
      suspend_req <= 1'b0;  resume_req <= 1'b0;
      case (mode_q)
        MD_READ: begin
          if (trk_cmd && at_cmd) begin
            if (wr_data == K_IDENT)      mode_q <= MD_IDENT;
            else if (wr_data == K_PGM)   mode_q <= MD_PGM_ARM;
            else if (wr_data == K_ERASE) mode_q <= MD_ESETUP;
          end
        end
        MD_SUSP: begin
          if (wr_en && (wr_data == K_SECTOR)) begin
            mode_q <= MD_ERASE;  susp_q <= 1'b0;
            if (started_q) resume_req <= 1'b1;
            else begin sector_erase_start <= 1'b1; started_q <= 1'b1; end
          end else if (trk_cmd && at_cmd) begin
            if (wr_data == K_IDENT)    mode_q <= MD_IDENT;
            else if (wr_data == K_PGM) mode_q <= MD_PGM_ARM;
          end
        end
        MD_IDENT: if (is_reset) mode_q <= susp_q ? MD_SUSP : MD_READ;
        MD_PGM_ARM: begin
          if (is_reset) mode_q <= susp_q ? MD_SUSP : MD_READ;
          else if (wr_en) begin prog_start <= 1'b1; mode_q <= MD_PGM; end
        end
        MD_PGM: begin
          if (eng_fail)      mode_q <= MD_FAIL;
          else if (eng_done) mode_q <= susp_q ? MD_SUSP : MD_READ;
        end
        MD_ESETUP: begin
          if (is_reset || trk_brk) mode_q <= MD_READ;
          else if (trk_cmd) begin
            if ((wr_data == K_CHIP) && at_cmd) begin
              chip_erase_start <= 1'b1;  map_q <= '1;
              chip_q <= 1'b1;  started_q <= 1'b1;  mode_q <= MD_ERASE;
            end else if (wr_data == K_SECTOR) begin
              map_q <= sect_bit;  chip_q <= 1'b0;  mode_q <= MD_WINDOW;
            end else mode_q <= MD_READ;
          end
        end
        MD_WINDOW: begin
          if (wr_en) begin
            if (wr_data == K_SECTOR) map_q <= map_q | sect_bit;
            else if (wr_data == K_SUSP) begin
              mode_q <= MD_SUSP;  susp_q <= 1'b1;  started_q <= 1'b0;
            end else begin mode_q <= MD_READ; map_q <= '0; end
          end else if (win_expire) begin
            sector_erase_start <= 1'b1;  started_q <= 1'b1;  mode_q <= MD_ERASE;
          end
        end
        MD_ERASE: begin
          if (eng_fail) mode_q <= MD_FAIL;
          else if (eng_done) begin
            mode_q <= MD_READ;  map_q <= '0;  started_q <= 1'b0;  chip_q <= 1'b0;
          end else if (wr_en && (wr_data == K_SUSP) && !chip_q) begin
            suspend_req <= 1'b1;  mode_q <= MD_SUSP;  susp_q <= 1'b1;
          end
        end
        MD_FAIL: begin
          if (is_reset) begin
            mode_q <= MD_READ;  map_q <= '0;
            susp_q <= 1'b0;  started_q <= 1'b0;  chip_q <= 1'b0;
          end
        end
        default: mode_q <= MD_READ;
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign sector_map = map_q;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
  import flash_cmd_pkg::*;
#(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [7:0]          wr_data,
  input logic                eng_done,
  input logic                eng_fail,
  input logic [3:0]          mode_o,
  input logic                prog_start,
  input logic                chip_erase_start,
  input logic                sector_erase_start,
  input logic                suspend_req,
  input logic                resume_req,
  input logic [NUM_SECT-1:0] sector_map
);
  assert_pulse_excl_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start, chip_erase_start, sector_erase_start, suspend_req, resume_req}));

  assert_prog_single_R3: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);

  assert_prog_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_PGM && !eng_done && !eng_fail) |=> (mode_o == MD_PGM));

  assert_erase_reset_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_ERASE && wr_en && wr_data == K_RESET && !eng_done && !eng_fail)
      |=> (mode_o == MD_ERASE));

  assert_chip_map_R5: assert property (@(posedge clk) disable iff (rst)
    chip_erase_start |-> (&sector_map));

  assert_sector_map_R7: assert property (@(posedge clk) disable iff (rst)
    sector_erase_start |-> (sector_map != '0));

  assert_suspend_mode_R9: assert property (@(posedge clk) disable iff (rst)
    suspend_req |-> (mode_o == MD_SUSP));

  assert_resume_src_R10: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> ($past(mode_o) == MD_SUSP));

  assert_fail_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_FAIL && !(wr_en && wr_data == K_RESET)) |=> (mode_o == MD_FAIL));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NUM_SECT(NUM_SECT)) chk_i (
  .clk                (clk),
  .rst                (rst),
  .wr_en              (wr_en),
  .wr_data            (wr_data),
  .eng_done           (eng_done),
  .eng_fail           (eng_fail),
  .mode_o             (mode_o),
  .prog_start         (prog_start),
  .chip_erase_start   (chip_erase_start),
  .sector_erase_start (sector_erase_start),
  .suspend_req        (suspend_req),
  .resume_req         (resume_req),
  .sector_map         (sector_map)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        eng_busy = 1'b0, eng_done = 1'b0, eng_fail = 1'b0;
  logic [3:0]  mode_o;
  logic        prog_start, chip_erase_start, sector_erase_start, suspend_req, resume_req;
  logic [7:0]  sector_map;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.CLK_FREQ_MHZ(1), .WINDOW_US(WIN)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_fail(eng_fail),
    .mode_o(mode_o), .prog_start(prog_start), .chip_erase_start(chip_erase_start),
    .sector_erase_start(sector_erase_start), .sector_map(sector_map),
    .suspend_req(suspend_req), .resume_req(resume_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h00555, 8'hAA);
    wr(19'h002AA, 8'h55);
  endtask

  task automatic esetup();
    unlock(); wr(19'h00555, 8'h80); unlock();
  endtask

  task automatic done_pulse();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 map", sector_map, 0);
    chk("R1 pulses", {prog_start, chip_erase_start, sector_erase_start, suspend_req, resume_req}, 0);

    // R2 identifier entry and exit
    unlock(); wr(19'h00555, 8'h90);
    chk("R2 ident", mode_o, 1);
    wr(19'h00000, 8'hF0);
    chk("R2 ident exit", mode_o, 0);

    // R3 program, R4 ignores
    unlock(); wr(19'h00555, 8'hA0);
    chk("R3 armed", mode_o, 2);
    wr(19'h12345, 8'h5A);
    chk("R3 prog_start", prog_start, 1);
    chk("R3 mode pgm", mode_o, 3);
    @(negedge clk);
    chk("R3 pulse width", prog_start, 0);
    unlock(); wr(19'h00555, 8'h90); wr(19'h00000, 8'hF0);
    chk("R4 pgm ignores", mode_o, 3);
    done_pulse();
    chk("R3 pgm done", mode_o, 0);

    // R5 chip erase, R4 ignores
    esetup(); wr(19'h00555, 8'h10);
    chk("R5 chip start", chip_erase_start, 1);
    chk("R5 mode", mode_o, 6);
    chk("R5 map", sector_map, 8'hFF);
    wr(19'h00000, 8'hB0);
    chk("R4 chip ignores suspend", mode_o, 6);
    chk("R4 no suspend_req", suspend_req, 0);
    wr(19'h00000, 8'hF0);
    chk("R4 chip ignores reset", mode_o, 6);
    done_pulse();
    chk("R5 chip done", mode_o, 0);

    // R6/R7 per-sector sweep with window length
    for (int s = 0; s < 8; s++) begin
      esetup(); wr(19'(s << 16) | 19'h01234, 8'h30);
      chk("R6 window mode", mode_o, 5);
      chk("R6 sector bit", sector_map, 1 << s);
      repeat (WIN - 1) @(negedge clk);
      chk("R7 window not yet over", mode_o, 5);
      @(negedge clk);
      chk("R7 sector start", sector_erase_start, 1);
      chk("R7 erase mode", mode_o, 6);
      done_pulse();
      chk("R7 erase done", mode_o, 0);
    end

    // R6/R7 accumulate all sectors with restarts
    esetup(); wr(19'h00000, 8'h30);
    for (int s = 1; s < 8; s++) begin
      repeat (3) @(negedge clk);
      wr(19'(s << 16), 8'h30);
    end
    chk("R6 all sectors", sector_map, 8'hFF);
    repeat (WIN - 1) @(negedge clk);
    chk("R7 restarted window", mode_o, 5);
    @(negedge clk);
    chk("R7 start after restart", sector_erase_start, 1);
    done_pulse();

    // R8 abort from window
    esetup(); wr(19'h20000, 8'h30);
    wr(19'h00000, 8'h90);
    chk("R8 abort mode", mode_o, 0);
    chk("R8 abort map", sector_map, 0);

    // R9 suspend in window, R11 suspended commands, R10 resume
    esetup(); wr(19'h50000, 8'h30);
    wr(19'h00000, 8'hB0);
    chk("R9 window suspend", mode_o, 7);
    chk("R9 no suspend_req", suspend_req, 0);
    unlock(); wr(19'h00555, 8'h80);
    chk("R11 erase setup rejected", mode_o, 7);
    unlock(); wr(19'h00555, 8'h90);
    chk("R11 ident in suspend", mode_o, 1);
    wr(19'h00000, 8'hF0);
    chk("R11 ident back to suspend", mode_o, 7);
    wr(19'h00000, 8'h30);
    chk("R10 deferred start", sector_erase_start, 1);
    chk("R10 mode erase", mode_o, 6);
    chk("R10 map kept", sector_map, 8'h20);
    wr(19'h00000, 8'hB0);
    chk("R9 suspend_req", suspend_req, 1);
    chk("R9 suspended", mode_o, 7);
    unlock(); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h00);
    chk("R11 prog in suspend", prog_start, 1);
    done_pulse();
    chk("R11 prog back to suspend", mode_o, 7);
    wr(19'h00000, 8'h30);
    chk("R10 resume_req", resume_req, 1);
    chk("R10 resumed", mode_o, 6);
    done_pulse();
    wr(19'h00000, 8'h30);
    chk("R10 resume in read ignored", mode_o, 0);
    chk("R10 no pulse", {resume_req, sector_erase_start}, 0);

    // R12 broken unlocks
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h11); wr(19'h00555, 8'h90);
    chk("R12 broken data", mode_o, 0);
    unlock(); wr(19'h00444, 8'h90);
    chk("R12 wrong cmd address", mode_o, 0);
    unlock(); wr(19'h00555, 8'h80);
    chk("R12 setup entered", mode_o, 4);
    wr(19'h00555, 8'hAA); wr(19'h00123, 8'h55);
    chk("R12 setup broken", mode_o, 0);

    // R13 fail
    unlock(); wr(19'h00555, 8'hA0); wr(19'h00001, 8'h00);
    eng_fail = 1'b1; @(negedge clk); eng_fail = 1'b0;
    chk("R13 fail", mode_o, 8);
    unlock(); wr(19'h00555, 8'h90);
    chk("R13 fail holds", mode_o, 8);
    wr(19'h00000, 8'hF0);
    chk("R13 fail cleared", mode_o, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule